// File: doc/BRIEF.md
# Software Write Protection Sequencer

This block sits in the write path of a byte-alterable nonvolatile memory, between the bus interface that produces accepted write cycles and the page buffer that collects them. Each write carries a 15-bit low address and an 8-bit data byte. The block watches that stream for two fixed command sequences made of address/data pairs. One sequence switches protection on and opens a single page-load window. The other sequence switches protection off. The block keeps the protection state bit. For each write it decides whether the write is forwarded to the page buffer, consumed silently as a command step, or blocked as illegal.

A change in protection takes effect only after a settling delay. This delay stands in for the write-cycle time and is given as the cycle-count parameter `TWC_CYCLES`. After reset the block is unprotected.

The write stream uses valid/ready on both sides and holds no buffering. A write that is forwarded passes straight through. Back-pressure from the page buffer (`out_ready` low) then reaches the source as `in_ready` low. A write that is not forwarded is accepted at once, with `in_ready` high and `out_valid` low. A write is accepted in a cycle where `in_valid` and `in_ready` are both high. The page buffer pulses `load_commit` when the collected load closes and is committed to programming.

Top module: `wprot_seq`

## Requirements
- R1: After reset `prot_on` and `illegal_wr` are 0. While unprotected, every write is forwarded with its address and data unchanged.
- R2: `out_valid` is high only together with `in_valid`. A forwarded write is accepted only when `out_ready` is high. When forwarding is not allowed, `in_ready` is 1 and `out_valid` is 0, whatever `out_ready` is.
- R3: The protect sequence is three consecutive accepted writes: data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. While unprotected, these writes are forwarded as ordinary data. `prot_on` becomes 1 exactly `TWC_CYCLES` clock edges after the edge that accepts the last write.
- R4: While `prot_on` is 1 and no load window is open, a write that is not a command step is blocked. It is not forwarded, and `illegal_wr` is 1 for exactly the one cycle after the edge that accepts it.
- R5: While protected, a write that is the next expected step of a sequence, or that is 0xAA at 0x5555, is consumed without being forwarded and without raising `illegal_wr`.
- R6: Completing the protect sequence opens a load window. Writes are then forwarded, even while protected, until a `load_commit` pulse closes the window. After that, writes are blocked again.
- R7: The unprotect sequence is six consecutive accepted writes: 0xAA at 0x5555, 0x55 at 0x2AAA, 0x80 at 0x5555, 0xAA at 0x5555, 0x55 at 0x2AAA, 0x20 at 0x5555. Completing it closes any open window. `prot_on` becomes 0 exactly `TWC_CYCLES` edges after the last of these writes is accepted.
- R8: An accepted write that is not the next expected step returns the matcher to idle. That same write is then treated as a possible first step, so 0xAA at 0x5555 starts a new sequence at once.
- R9: A sequence completed while an earlier one is still settling restarts the `TWC_CYCLES` count. The newest sequence decides the final protection state.
- R10: `illegal_wr` rises only after a blocked write that was accepted while `prot_on` was 1. It never rises while unprotected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming write cycle is present |
| in_ready | output | 1 | Incoming write cycle is accepted this cycle |
| in_addr | input | 15 | Low address of the write |
| in_data | input | 8 | Data byte of the write |
| out_valid | output | 1 | Write forwarded to the page buffer |
| out_ready | input | 1 | Page buffer can take a write |
| out_addr | output | 15 | Forwarded address |
| out_data | output | 8 | Forwarded data |
| load_commit | input | 1 | Pulse: the current page load is committed, closing the load window |
| prot_on | output | 1 | Protection state bit |
| illegal_wr | output | 1 | One-cycle pulse after a blocked write |

## Verification
Directed passes feed clean sequences, which show that the matcher advances and that the settling count lands on the exact edge. Broken sequences, such as a stray byte after two steps or a doubled 0xAA, show that the matcher resets and then re-tests the breaking write as a first step. A sequence started while another is still settling shows which target wins. Stalls on `out_ready` in the protected and unprotected states tell forwarded writes apart from consumed ones. A long random stream, weighted towards command bytes and mixed with `load_commit` pulses, is compared cycle by cycle with a bench model. It separates data forwarding, silent command consumption and illegal blocking in orderings that the directed cases do not reach.

// File: rtl/wprot_pkg.sv
`timescale 1ns/1ps
package wprot_pkg;
  // Progress through the command sequences
  typedef enum logic [2:0] {
    M_IDLE, M_K1, M_K2, M_K3, M_K4, M_K5
  } mstate_t;

  // Classification of one address/data pair
  typedef enum logic [2:0] {
    K_NONE, K_AA_LO, K_55_HI, K_A0_LO, K_80_LO, K_20_LO
  } key_t;

  localparam logic [14:0] CMD_ADR_LO = 15'h5555;
  localparam logic [14:0] CMD_ADR_HI = 15'h2AAA;
  localparam logic [7:0]  CMD_D_AA   = 8'hAA;
  localparam logic [7:0]  CMD_D_55   = 8'h55;
  localparam logic [7:0]  CMD_D_A0   = 8'hA0;
  localparam logic [7:0]  CMD_D_80   = 8'h80;
  localparam logic [7:0]  CMD_D_20   = 8'h20;
endpackage

// File: rtl/wprot_matcher.sv
`timescale 1ns/1ps
module wprot_matcher
  import wprot_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              is_step,
  output logic              en_done,
  output logic              dis_done
);
  mstate_t st, st_nxt;
  key_t    key;
  logic    adv, en_hit, dis_hit;
  logic    at_lo, at_hi;

  assign at_lo = (addr == ADDR_W'(CMD_ADR_LO));
  assign at_hi = (addr == ADDR_W'(CMD_ADR_HI));

  always_comb begin
    key = K_NONE;
    if (at_lo && data == DATA_W'(CMD_D_AA)) key = K_AA_LO;
    else if (at_hi && data == DATA_W'(CMD_D_55)) key = K_55_HI;
    else if (at_lo && data == DATA_W'(CMD_D_A0)) key = K_A0_LO;
    else if (at_lo && data == DATA_W'(CMD_D_80)) key = K_80_LO;
    else if (at_lo && data == DATA_W'(CMD_D_20)) key = K_20_LO;
  end

  always_comb begin
    adv     = 1'b0;
    en_hit  = 1'b0;
    dis_hit = 1'b0;
    st_nxt  = (key == K_AA_LO) ? M_K1 : M_IDLE;  // restart path
    case (st)
      M_IDLE: if (key == K_AA_LO) begin adv = 1'b1; st_nxt = M_K1; end
      M_K1:   if (key == K_55_HI) begin adv = 1'b1; st_nxt = M_K2; end
      M_K2: begin
        if (key == K_A0_LO) begin
          adv = 1'b1; en_hit = 1'b1; st_nxt = M_IDLE;
        end else if (key == K_80_LO) begin
          adv = 1'b1; st_nxt = M_K3;
        end
      end
      M_K3:   if (key == K_AA_LO) begin adv = 1'b1; st_nxt = M_K4; end
      M_K4:   if (key == K_55_HI) begin adv = 1'b1; st_nxt = M_K5; end
      M_K5: begin
        if (key == K_20_LO) begin
          adv = 1'b1; dis_hit = 1'b1; st_nxt = M_IDLE;
        end
      end
      default: ;
    endcase
  end

  assign is_step  = adv || (key == K_AA_LO);
  assign en_done  = fire && en_hit;
  assign dis_done = fire && dis_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)    st <= M_IDLE;
    else if (fire) st <= st_nxt;
  end
endmodule

// File: rtl/wprot_timer.sv
`timescale 1ns/1ps
module wprot_timer #(
  parameter int TWC_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_set,
  input  logic arm_clr,
  output logic prot_on,
  output logic busy
);
  localparam int CW = $clog2(TWC_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          target;

  assign busy = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      target  <= 1'b0;
      prot_on <= 1'b0;
    end else if (arm_set || arm_clr) begin
      cnt    <= CW'(TWC_CYCLES);
      target <= arm_set;
    end else if (busy) begin
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) prot_on <= target;
    end
  end
endmodule

// File: rtl/wprot_gate.sv
`timescale 1ns/1ps
module wprot_gate #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  input  logic              prot_on,
  input  logic              is_step,
  input  logic              en_done,
  input  logic              dis_done,
  input  logic              load_commit,
  output logic              fire,
  output logic              win_open,
  output logic              illegal_wr
);
  logic allow;

  assign allow     = !prot_on || win_open;
  assign out_valid = in_valid && allow;
  assign in_ready  = allow ? out_ready : 1'b1;
  assign fire      = in_valid && in_ready;
  assign out_addr  = in_addr;
  assign out_data  = in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_open   <= 1'b0;
      illegal_wr <= 1'b0;
    end else begin
      illegal_wr <= fire && !allow && !is_step;
      if (en_done)                      win_open <= 1'b1;
      else if (dis_done || load_commit) win_open <= 1'b0;
    end
  end
endmodule

// File: rtl/wprot_seq.sv
`timescale 1ns/1ps
module wprot_seq #(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int TWC_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  input  logic              load_commit,
  output logic              prot_on,
  output logic              illegal_wr
);
  logic fire, is_step, en_done, dis_done, win_open, tmr_busy;

  wprot_matcher #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .clk(clk), .rst_n(rst_n), .fire(fire), .addr(in_addr), .data(in_data),
    .is_step(is_step), .en_done(en_done), .dis_done(dis_done)
  );

  wprot_timer #(.TWC_CYCLES(TWC_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .arm_set(en_done), .arm_clr(dis_done),
    .prot_on(prot_on), .busy(tmr_busy)
  );

  wprot_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_gate (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_data(out_data),
    .prot_on(prot_on), .is_step(is_step), .en_done(en_done), .dis_done(dis_done),
    .load_commit(load_commit), .fire(fire), .win_open(win_open), .illegal_wr(illegal_wr)
  );
endmodule

// File: rtl/wprot_checker.sv
`timescale 1ns/1ps
module wprot_checker #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] in_addr,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic [DATA_W-1:0] out_data,
  input logic              prot_on,
  input logic              illegal_wr,
  input logic              win_open,
  input logic              tmr_busy
);
  // R1
  fwd_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (in_valid && out_addr == in_addr && out_data == in_data));

  // R2
  stall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |-> (out_valid && !out_ready));

  // R4
  gate_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!prot_on || win_open));

  // R10
  illegal_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_wr |-> $past(in_valid && in_ready && !out_valid && prot_on));

  // R3
  prot_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_on) |-> $past(tmr_busy));

  // R7
  prot_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_on) |-> $past(tmr_busy));
endmodule

bind wprot_seq wprot_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_addr(in_addr), .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
  .out_addr(out_addr), .out_data(out_data), .prot_on(prot_on), .illegal_wr(illegal_wr),
  .win_open(win_open), .tmr_busy(tmr_busy)
);

// File: tb/wprot_seq_bench.sv
`timescale 1ns/1ps
module wprot_seq_bench;
  localparam int TWC = 12;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, in_valid, in_ready, out_valid, out_ready, load_commit;
  logic        prot_on, illegal_wr;
  logic [14:0] in_addr, out_addr;
  logic [7:0]  in_data, out_data;

  wprot_seq #(.ADDR_W(15), .DATA_W(8), .TWC_CYCLES(TWC)) u_wprot_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_data(out_data), .load_commit(load_commit),
    .prot_on(prot_on), .illegal_wr(illegal_wr)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // Reference model state, built from the requirements
  int m_st = 0, m_cnt = 0;
  bit m_prot = 0, m_tgt = 0, m_win = 0, m_ill = 0;

  function automatic int keyof(logic [14:0] a, logic [7:0] d);
    if (a == 15'h5555 && d == 8'hAA) return 1;
    if (a == 15'h2AAA && d == 8'h55) return 2;
    if (a == 15'h5555 && d == 8'hA0) return 3;
    if (a == 15'h5555 && d == 8'h80) return 4;
    if (a == 15'h5555 && d == 8'h20) return 5;
    return 0;
  endfunction

  // next sequence position when the write is the expected step, else -1
  function automatic int advance(int st, int k);
    case (st)
      0: if (k == 1) return 1;
      1: if (k == 2) return 2;
      2: begin if (k == 3) return 0; if (k == 4) return 3; end
      3: if (k == 1) return 4;
      4: if (k == 2) return 5;
      5: if (k == 5) return 0;
      default: ;
    endcase
    return -1;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(bit v, logic [14:0] a, logic [7:0] d, bit ordy, bit lc, string tag);
    int k, nx;
    bit allow, step, fire, en, dis;
    @(negedge clk);
    in_valid = v; in_addr = a; in_data = d; out_ready = ordy; load_commit = lc;
    #1;
    k = keyof(a, d);
    nx = advance(m_st, k);
    allow = !m_prot || m_win;
    step = (nx >= 0) || (k == 1);
    fire = v && (allow ? ordy : 1'b1);
    chk(tag, "out_valid", int'(out_valid), int'(v && allow));
    chk(tag, "in_ready", int'(in_ready), int'(allow ? ordy : 1'b1));
    if (v && allow) begin
      chk(tag, "out_addr", int'(out_addr), int'(a));
      chk(tag, "out_data", int'(out_data), int'(d));
    end
    en  = fire && m_st == 2 && k == 3;
    dis = fire && m_st == 5 && k == 5;
    @(posedge clk);
    #1;
    if (fire) m_st = (nx >= 0) ? nx : ((k == 1) ? 1 : 0);
    m_ill = fire && !allow && !step;
    if (en || dis) begin m_cnt = TWC; m_tgt = en; end
    else if (m_cnt != 0) begin
      if (m_cnt == 1) m_prot = m_tgt;
      m_cnt--;
    end
    if (en) m_win = 1'b1;
    else if (dis || lc) m_win = 1'b0;
    chk(tag, "prot_on", int'(prot_on), int'(m_prot));
    chk(tag, "illegal_wr", int'(illegal_wr), int'(m_ill));
  endtask

  task automatic wr(logic [14:0] a, logic [7:0] d, string tag);
    cyc(1'b1, a, d, 1'b1, 1'b0, tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 15'h0, 8'h0, 1'b1, 1'b0, tag);
  endtask

  task automatic protect_seq(string tag);
    wr(15'h5555, 8'hAA, tag); wr(15'h2AAA, 8'h55, tag); wr(15'h5555, 8'hA0, tag);
  endtask

  task automatic unprotect_seq(string tag);
    wr(15'h5555, 8'hAA, tag); wr(15'h2AAA, 8'h55, tag); wr(15'h5555, 8'h80, tag);
    wr(15'h5555, 8'hAA, tag); wr(15'h2AAA, 8'h55, tag); wr(15'h5555, 8'h20, tag);
  endtask

  initial begin
    #(64'd20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; in_addr = '0; in_data = '0;
    out_ready = 1'b1; load_commit = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    chk("R1", "reset prot_on", int'(prot_on), 0);
    chk("R1", "reset illegal_wr", int'(illegal_wr), 0);

    // R1: plain data forwarded while unprotected
    wr(15'h0123, 8'h3C, "R1"); wr(15'h7FFF, 8'hFF, "R1"); wr(15'h5555, 8'h11, "R1");
    // R2: back-pressure reaches the source while forwarding
    cyc(1'b1, 15'h0042, 8'h99, 1'b0, 1'b0, "R2");
    cyc(1'b1, 15'h0042, 8'h99, 1'b1, 1'b0, "R2");
    // R3: protect while unprotected, exact settling edge
    protect_seq("R3");
    idle(TWC + 2, "R3");
    cyc(1'b0, 15'h0, 8'h0, 1'b1, 1'b1, "R6");  // close the window it opened
    // R4: blocked writes while protected, also under back-pressure (R2)
    wr(15'h0100, 8'h77, "R4");
    cyc(1'b1, 15'h0101, 8'h78, 1'b0, 1'b0, "R2");
    idle(1, "R4");
    // R5: command steps consumed silently
    wr(15'h5555, 8'hAA, "R5"); wr(15'h2AAA, 8'h55, "R5"); idle(1, "R5");
    // R8: broken sequence then restart by the breaking byte
    wr(15'h0003, 8'h00, "R8");
    wr(15'h5555, 8'hAA, "R8"); wr(15'h5555, 8'hAA, "R8");
    wr(15'h2AAA, 8'h55, "R8"); wr(15'h5555, 8'hA0, "R8");
    // R6: window forwards writes until load_commit
    wr(15'h0200, 8'h01, "R6"); wr(15'h02FF, 8'h02, "R6");
    cyc(1'b1, 15'h0210, 8'h03, 1'b0, 1'b0, "R6");
    cyc(1'b0, 15'h0, 8'h0, 1'b1, 1'b1, "R6");
    wr(15'h0204, 8'h05, "R6");
    idle(TWC + 1, "R6");
    // R7: unprotect and settle
    unprotect_seq("R7");
    idle(TWC + 2, "R7");
    wr(15'h0300, 8'h5A, "R7");
    // R9: later sequence replaces a pending one
    protect_seq("R9"); idle(4, "R9");
    unprotect_seq("R9"); idle(TWC + 2, "R9");
    protect_seq("R9"); idle(3, "R9");
    unprotect_seq("R9"); idle(5, "R9");
    protect_seq("R9"); idle(TWC + 2, "R9");
    cyc(1'b0, 15'h0, 8'h0, 1'b1, 1'b1, "R9");

    // R10: random stream weighted towards command bytes
    for (int n = 0; n < 4000; n++) begin
      logic [14:0] a;
      logic [7:0]  d;
      int r;
      r = $urandom % 9;
      case (r)
        0: begin a = 15'h5555; d = 8'hAA; end
        1: begin a = 15'h2AAA; d = 8'h55; end
        2: begin a = 15'h5555; d = 8'hA0; end
        3: begin a = 15'h5555; d = 8'h80; end
        4: begin a = 15'h5555; d = 8'h20; end
        default: begin a = 15'($urandom); d = 8'($urandom); end
      endcase
      cyc(($urandom % 4) != 0, a, d, ($urandom % 4) != 0, ($urandom % 24) == 0, "R10");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule